// File: doc/BRIEF.md
# Memory Window Bridge with Reply Timeout

This block sits on a simple register bus (address, read strobe, write strobe, write data) and claims one aligned address window for an attached memory-like target, such as an on-chip RAM or a slow configuration port. When an access lands inside the window and its direction is permitted, the bridge passes the in-window offset, the direction and the write data to the target. It then waits for the target to raise a data-valid reply.

If the reply comes, the requester gets a clean response, carrying read data when the access was a read. If no reply comes within a parameterised number of cycles, the requester gets a bus error instead. Accesses whose direction the window forbids are never passed to the target and are refused at once. Addresses outside the window draw no reaction at all, so a neighbouring decoder can claim them.

Only one transaction is in flight at a time. The ready output tells the requester when a new strobe will be taken.

Top module: `mem_window_bridge`

## Requirements
- R1: After reset, `bus_ready` is 1 and `rsp_valid` and `mem_en` are 0.
- R2: A permitted access that hits the window raises `mem_en` for exactly the cycle after the strobe. In that cycle `mem_addr` equals the bus address AND (WIN_SIZE-1), and `mem_we` is 1 for a write and 0 for a read. For a write, `mem_wdata` holds the low MEM_DW bits of the write data. A hit means that the address bits at and above log2(WIN_SIZE) equal those of WIN_BASE.
- R3: A strobe whose address misses the window gives no `mem_en` and no response, and `bus_ready` stays 1.
- R4: A read whose `mem_dv` is sampled high produces a response one cycle later, with `rsp_err`=0 and `rsp_rdata` equal to `mem_rdata` zero-extended to BUS_DW.
- R5: A write that receives its `mem_dv` produces a response with `rsp_err`=0 and `rsp_rdata`=0, whatever `mem_rdata` carries.
- R6: The target may answer in any of the first TIMEOUT cycles, counting from the cycle in which `mem_en` is high. If `mem_dv` is absent in all of them, an error response (`rsp_err`=1, `rsp_rdata`=0) appears in the cycle after the last one. This gives a strobe-to-response distance of TIMEOUT+1 cycles.
- R7: PERM bit 0 allows reads and PERM bit 1 allows writes. A hitting access of a forbidden direction is not forwarded and receives an error response in the cycle after the strobe.
- R8: `bus_ready` is 0 from the cycle after a hitting strobe until the response cycle. Strobes seen while it is 0 are ignored: nothing is forwarded and no write reaches the target.
- R9: A `mem_dv` that arrives while no transaction waits for it, such as one after a timeout, produces no response.
- R10: A hitting strobe with both read and write asserted is not forwarded and receives an error response in the next cycle.
- R11: `rsp_valid` and `mem_en` are single-cycle pulses, and `bus_ready` returns to 1 in the cycle after a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Bus byte/word address |
| bus_rd | input | 1 | Read strobe, sampled when ready |
| bus_wr | input | 1 | Write strobe, sampled when ready |
| bus_wdata | input | BUS_DW | Write data |
| bus_ready | output | 1 | Bridge can take a new strobe |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a bus error |
| rsp_rdata | output | BUS_DW | Read data, zero-extended |
| mem_en | output | 1 | One-cycle request to target |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | log2(WIN_SIZE) | Offset inside the window |
| mem_wdata | output | MEM_DW | Data to target |
| mem_dv | input | 1 | Target reply (data valid) |
| mem_rdata | input | MEM_DW | Target read data |

## Verification
The bench builds three bridges on one shared bus. The first is a read-write window of 256 entries of 13 bits at 0x0100. The other two are 64-entry, 8-bit windows at 0x0200 (read-only) and 0x0300 (write-only). All three use a timeout of 12 cycles, which makes the accept-versus-expire boundary (reply delays of 11, 12 and 14 cycles) reachable within a few dozen cycles. The 13-bit data width exercises both write truncation and read zero-extension. The read-only and write-only windows expose every permission outcome. A behavioural target with a programmable reply delay drives late, missing and stray data-valid replies.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } mwb_state_e;

  localparam logic [1:0] PERM_RD = 2'b01;
  localparam logic [1:0] PERM_WR = 2'b10;
  localparam logic [1:0] PERM_RW = 2'b11;
endpackage

// File: rtl/mwb_decode.sv
`timescale 1ns/1ps
module mwb_decode #(
  parameter int               BUS_AW   = 16,
  parameter int               WIN_SIZE = 1024,
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h0400,
  parameter logic [1:0]       PERM     = 2'b11,
  localparam int              MAW      = $clog2(WIN_SIZE)
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              hit,
  output logic              legal,
  output logic              is_rd,
  output logic [MAW-1:0]    off
);
  // aligned power-of-two window: only the bits above the offset are compared
  assign hit   = (bus_addr[BUS_AW-1:MAW] == WIN_BASE[BUS_AW-1:MAW]);
  assign off   = bus_addr[MAW-1:0];
  assign is_rd = bus_rd;

  generate
    if (PERM == 2'b11) begin : g_rw
      assign legal = bus_rd ^ bus_wr;
    end else if (PERM == 2'b01) begin : g_ro
      assign legal = bus_rd & ~bus_wr;
    end else if (PERM == 2'b10) begin : g_wo
      assign legal = bus_wr & ~bus_rd;
    end else begin : g_none
      assign legal = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mwb_timer.sv
`timescale 1ns/1ps
module mwb_timer #(
  parameter int  LIMIT = 300,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TMO_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT - 1)); // R6
endmodule

// File: rtl/mwb_ctrl.sv
`timescale 1ns/1ps
module mwb_ctrl
  import mwb_pkg::*;
#(
  parameter int MAW    = 10,
  parameter int MEM_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              hit,
  input  logic              legal,
  input  logic              is_rd,
  input  logic [MAW-1:0]    off,
  input  logic [MEM_DW-1:0] wdata,
  input  logic              mem_dv,
  input  logic [MEM_DW-1:0] mem_rdata,
  input  logic              tmo_expired,
  output logic              ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [MEM_DW-1:0] rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic              tmr_clear,
  output logic              tmr_step
);
  mwb_state_e state;
  logic       rd_q;
  logic       accept;

  assign ready     = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign accept    = ready && req && hit;
  assign tmr_clear = accept;
  assign tmr_step  = (state == ST_WAIT) && !mem_dv;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_q      <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      mem_en <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (legal) begin
              state     <= ST_WAIT;
              mem_en    <= 1'b1;
              mem_we    <= !is_rd;
              mem_addr  <= off;
              mem_wdata <= is_rd ? '0 : wdata;
              rd_q      <= is_rd;
            end else begin
              state    <= ST_DONE;
              rsp_err  <= 1'b1;
              rsp_data <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (mem_dv) begin
            state    <= ST_DONE;
            rsp_err  <= 1'b0;
            rsp_data <= rd_q ? mem_rdata : '0;
          end else if (tmo_expired) begin
            state    <= ST_DONE;
            rsp_err  <= 1'b1;
            rsp_data <= '0;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid && ready); // R11
  AST_EN_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en); // R11
  AST_STRAY_DV: assert property (@(posedge clk) disable iff (rst)
    ready && mem_dv && !req |=> !rsp_valid); // R9
  AST_WRITE_NODATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err && !rd_q |-> rsp_data == '0); // R5
  AST_ERR_NODATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_data == '0); // R6
endmodule

// File: rtl/mem_window_bridge.sv
`timescale 1ns/1ps
module mem_window_bridge
  import mwb_pkg::*;
#(
  parameter int               BUS_AW   = 16,
  parameter int               BUS_DW   = 32,
  parameter int               MEM_DW   = 16,
  parameter int               WIN_SIZE = 1024,
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h0400,
  parameter logic [1:0]       PERM     = PERM_RW,
  parameter int               TIMEOUT  = 300,
  localparam int              MAW      = $clog2(WIN_SIZE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  input  logic              mem_dv,
  input  logic [MEM_DW-1:0] mem_rdata
);
  logic              win_hit;
  logic              win_legal;
  logic              win_is_rd;
  logic [MAW-1:0]    win_off;
  logic [MEM_DW-1:0] wdata_fit;
  logic [MEM_DW-1:0] rsp_data_m;
  logic              tmr_clear;
  logic              tmr_step;
  logic              tmr_expired;
  logic              bus_req;

  assign bus_req = bus_rd | bus_wr;

  // fit bus write data to the memory width
  generate
    if (MEM_DW < BUS_DW) begin : g_wd_trunc
      logic unused_wd_hi;
      assign unused_wd_hi = ^bus_wdata[BUS_DW-1:MEM_DW];
      assign wdata_fit    = bus_wdata[MEM_DW-1:0];
    end else if (MEM_DW == BUS_DW) begin : g_wd_same
      assign wdata_fit = bus_wdata;
    end else begin : g_wd_ext
      assign wdata_fit = {{(MEM_DW-BUS_DW){1'b0}}, bus_wdata};
    end
  endgenerate

  // zero-extend returned data to the bus width
  generate
    if (BUS_DW > MEM_DW) begin : g_rd_ext
      assign rsp_rdata = {{(BUS_DW-MEM_DW){1'b0}}, rsp_data_m};
    end else if (BUS_DW == MEM_DW) begin : g_rd_same
      assign rsp_rdata = rsp_data_m;
    end else begin : g_rd_trunc
      logic unused_rd_hi;
      assign unused_rd_hi = ^rsp_data_m[MEM_DW-1:BUS_DW];
      assign rsp_rdata    = rsp_data_m[BUS_DW-1:0];
    end
  endgenerate

  mwb_decode #(
    .BUS_AW  (BUS_AW),
    .WIN_SIZE(WIN_SIZE),
    .WIN_BASE(WIN_BASE),
    .PERM    (PERM)
  ) u_decode (
    .bus_addr(bus_addr),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .hit     (win_hit),
    .legal   (win_legal),
    .is_rd   (win_is_rd),
    .off     (win_off)
  );

  mwb_timer #(
    .LIMIT(TIMEOUT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (tmr_clear),
    .step   (tmr_step),
    .expired(tmr_expired)
  );

  mwb_ctrl #(
    .MAW   (MAW),
    .MEM_DW(MEM_DW)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req        (bus_req),
    .hit        (win_hit),
    .legal      (win_legal),
    .is_rd      (win_is_rd),
    .off        (win_off),
    .wdata      (wdata_fit),
    .mem_dv     (mem_dv),
    .mem_rdata  (mem_rdata),
    .tmo_expired(tmr_expired),
    .ready      (bus_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_data   (rsp_data_m),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tmr_clear  (tmr_clear),
    .tmr_step   (tmr_step)
  );

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    bus_ready && bus_req && !win_hit |=> !mem_en && !rsp_valid && bus_ready); // R3
  AST_FORBID_REFUSE: assert property (@(posedge clk) disable iff (rst)
    bus_ready && bus_req && win_hit && !win_legal |=> rsp_valid && rsp_err && !mem_en); // R7
  AST_LEGAL_FORWARD: assert property (@(posedge clk) disable iff (rst)
    bus_ready && win_hit && win_legal |=> mem_en && !bus_ready); // R2
  AST_BUSY_WHILE_EN: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> !bus_ready); // R8
endmodule

// File: tb/tb_mem_window_bridge.sv
`timescale 1ns/1ps
module tb_mem_window_bridge;
  import mwb_pkg::*;

  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int TMO = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata;

  logic [2:0]    rdy, rv, re, men, mwe;
  logic [DW-1:0] rdat [3];
  logic [31:0]   maddr [3];
  logic [31:0]   mwd [3];

  // main read-write window
  logic [7:0]  d_addr;
  logic [12:0] d_wdata, d_rdata;
  logic        d_dv;
  // read-only and write-only windows
  logic [5:0]  r_addr, w_addr;
  logic [7:0]  r_wdata, w_wdata, r_rdata, w_rdata;
  logic        r_dv, w_dv;

  mem_window_bridge #(.BUS_AW(AW), .BUS_DW(DW), .MEM_DW(13), .WIN_SIZE(256),
    .WIN_BASE(16'h0100), .PERM(PERM_RW), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_ready(rdy[0]), .rsp_valid(rv[0]), .rsp_err(re[0]),
    .rsp_rdata(rdat[0]), .mem_en(men[0]), .mem_we(mwe[0]), .mem_addr(d_addr),
    .mem_wdata(d_wdata), .mem_dv(d_dv), .mem_rdata(d_rdata));

  mem_window_bridge #(.BUS_AW(AW), .BUS_DW(DW), .MEM_DW(8), .WIN_SIZE(64),
    .WIN_BASE(16'h0200), .PERM(PERM_RD), .TIMEOUT(TMO)) dut_ro (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_ready(rdy[1]), .rsp_valid(rv[1]), .rsp_err(re[1]),
    .rsp_rdata(rdat[1]), .mem_en(men[1]), .mem_we(mwe[1]), .mem_addr(r_addr),
    .mem_wdata(r_wdata), .mem_dv(r_dv), .mem_rdata(r_rdata));

  mem_window_bridge #(.BUS_AW(AW), .BUS_DW(DW), .MEM_DW(8), .WIN_SIZE(64),
    .WIN_BASE(16'h0300), .PERM(PERM_WR), .TIMEOUT(TMO)) dut_wo (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_ready(rdy[2]), .rsp_valid(rv[2]), .rsp_err(re[2]),
    .rsp_rdata(rdat[2]), .mem_en(men[2]), .mem_we(mwe[2]), .mem_addr(w_addr),
    .mem_wdata(w_wdata), .mem_dv(w_dv), .mem_rdata(w_rdata));

  assign maddr[0] = {24'b0, d_addr};
  assign maddr[1] = {26'b0, r_addr};
  assign maddr[2] = {26'b0, w_addr};
  assign mwd[0]   = {19'b0, d_wdata};
  assign mwd[1]   = {24'b0, r_wdata};
  assign mwd[2]   = {24'b0, w_wdata};

  // behavioural target with programmable reply delay (0 = never)
  logic [12:0] mem_arr [256];
  int          lat_cfg;
  logic        m_busy;
  int          m_cnt;
  logic [7:0]  m_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
    end else if (men[0]) begin
      m_busy <= 1'b1;
      m_cnt  <= 1;
      m_addr <= d_addr;
      if (mwe[0]) mem_arr[d_addr] <= d_wdata;
    end else if (m_busy) begin
      if (m_cnt == lat_cfg) m_busy <= 1'b0;
      else m_cnt <= m_cnt + 1;
    end
  end
  assign d_dv    = m_busy && (m_cnt == lat_cfg);
  assign d_rdata = mem_arr[m_addr];

  logic       r_dv_q, w_dv_q;
  logic [5:0] r_addr_q;
  always @(posedge clk) begin
    r_dv_q <= rst ? 1'b0 : men[1];
    w_dv_q <= rst ? 1'b0 : men[2];
    if (men[1]) r_addr_q <= r_addr;
  end
  assign r_dv    = r_dv_q;
  assign w_dv    = w_dv_q;
  assign r_rdata = {2'b10, r_addr_q};
  assign w_rdata = 8'hFF;

  // scoreboard
  typedef struct {
    int          src;
    bit          err;
    logic [31:0] data;
    int          dly;
    int          t0;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  logic [2:0] prv = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < 3; s++) begin
        if (rv[s]) begin
          exp_t e;
          n_chk++;
          if (prv[s]) begin
            n_bad++;
            $display("FAIL R11 src %0d response held: actual 2 cycles expected 1", s);
          end
          if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R9 src %0d stray response: actual err=%0b data=%h expected none",
                     s, re[s], rdat[s]);
          end else begin
            e = sb.pop_front();
            if (e.src != s || e.err != re[s] || e.data != rdat[s] || (cyc - e.t0) != e.dly) begin
              n_bad++;
              $display("FAIL %s actual src=%0d err=%0b data=%h dly=%0d expected src=%0d err=%0b data=%h dly=%0d",
                       e.tag, s, re[s], rdat[s], cyc - e.t0, e.src, e.err, e.data, e.dly);
            end
          end
        end
      end
      prv = rv;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 60 && sb.size() != 0; i++) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s missing response actual none expected %0d", tag, sb.size());
      sb.delete();
    end
    @(negedge clk);
  endtask

  task automatic push(input int src, input bit err, input logic [31:0] data,
                      input int dly, input string tag);
    exp_t e;
    e.src = src; e.err = err; e.data = data; e.dly = dly; e.t0 = cyc; e.tag = tag;
    sb.push_back(e);
  endtask

  // one access; fwd says whether the target should see a request
  task automatic access(input int src, input bit rd, input bit wr, input logic [15:0] a,
                        input logic [31:0] wd, input bit fwd, input bit eerr,
                        input logic [31:0] edata, input int edly, input string tag);
    logic [31:0] mask;
    logic [31:0] dmask;
    mask  = (src == 0) ? 32'hFF : 32'h3F;
    dmask = (src == 0) ? 32'h1FFF : 32'hFF;
    @(negedge clk);
    push(src, eerr, edata, edly, tag);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(men[src] == fwd, "R2", "mem_en", {31'b0, men[src]}, {31'b0, fwd});
    check(rdy[src] == 1'b0, "R8", "ready after strobe", {31'b0, rdy[src]}, 32'd0);
    if (fwd) begin
      check(maddr[src] == ({16'b0, a} & mask), "R2", "mem_addr", maddr[src], {16'b0, a} & mask);
      check(mwe[src] == wr, "R2", "mem_we", {31'b0, mwe[src]}, {31'b0, wr});
      if (wr) check(mwd[src] == (wd & dmask), "R2", "mem_wdata", mwd[src], wd & dmask);
    end
    wait_drain(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] wd;
    logic [15:0] a;
    for (int i = 0; i < 256; i++) mem_arr[i] = 13'(i * 7 + 3);
    lat_cfg = 1;
    rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rdy == 3'b111, "R1", "ready", {29'b0, rdy}, 32'h7);
    check(rv == 3'b000 && men == 3'b000, "R1", "valid/en", {26'b0, rv, men}, 32'h0);

    // R5 write, R2 forwarding with truncation
    lat_cfg = 1;
    access(0, 0, 1, 16'h0110, 32'hDEAD_BEEF, 1, 0, 32'h0, 3, "R5");
    // R4 read back, zero-extended
    lat_cfg = 3;
    access(0, 1, 0, 16'h0110, 32'h0, 1, 0, 32'h0000_1EEF, 5, "R4");
    // R6 reply in last allowed cycle is accepted
    lat_cfg = TMO - 1;
    access(0, 1, 0, 16'h01FF, 32'h0, 1, 0, 32'h0000_06FC, TMO + 1, "R6");
    // R6 reply one cycle too late -> error
    lat_cfg = TMO;
    access(0, 1, 0, 16'h0100, 32'h0, 1, 1, 32'h0, TMO + 1, "R6");
    // R9 reply long after timeout -> error once, stray reply ignored
    lat_cfg = TMO + 2;
    access(0, 1, 0, 16'h0120, 32'h0, 1, 1, 32'h0, TMO + 1, "R9");
    repeat (6) @(negedge clk);
    check(rdy[0] == 1'b1, "R9", "ready after stray reply", {31'b0, rdy[0]}, 32'd1);

    // R8 strobe while busy is ignored
    lat_cfg = 8;
    @(negedge clk);
    push(0, 0, 32'h0000_0153, 10, "R8");
    bus_addr = 16'h0130; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 16'h0140; bus_wr = 1'b1; bus_wdata = 32'h0000_1234;
    @(negedge clk);
    bus_wr = 1'b0;
    check(men[0] == 1'b0, "R8", "mem_en on busy strobe", {31'b0, men[0]}, 32'd0);
    wait_drain("R8");
    lat_cfg = 1;
    access(0, 1, 0, 16'h0140, 32'h0, 1, 0, 32'h0000_01C3, 3, "R8");

    // R10 both strobes
    access(0, 1, 1, 16'h0150, 32'h5, 0, 1, 32'h0, 1, "R10");

    // R7 permissions
    access(1, 0, 1, 16'h0210, 32'h77, 0, 1, 32'h0, 1, "R7");
    access(1, 1, 0, 16'h0225, 32'h0, 1, 0, 32'h0000_00A5, 3, "R7");
    access(2, 1, 0, 16'h0305, 32'h0, 0, 1, 32'h0, 1, "R7");
    access(2, 0, 1, 16'h0333, 32'h0000_ABCD, 1, 0, 32'h0, 3, "R5");

    // R3 misses
    @(negedge clk);
    bus_addr = 16'h0500; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(men == 3'b000 && rdy == 3'b111, "R3", "en/ready after miss", {26'b0, men, rdy}, 32'h7);
    bus_addr = 16'h0040; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(men == 3'b000 && rdy == 3'b111, "R3", "en/ready after miss", {26'b0, men, rdy}, 32'h7);
    repeat (4) @(negedge clk);

    // R4/R5 sweep with several patterns and reply delays
    for (int k = 0; k < 6; k++) begin
      a  = 16'h0100 + 16'(k * 37);
      wd = 32'h1357_0000 + 32'(k) * 32'h0000_0BAD;
      lat_cfg = (k % 4) + 1;
      access(0, 0, 1, a, wd, 1, 0, 32'h0, lat_cfg + 2, "R5");
      access(0, 1, 0, a, 32'h0, 1, 0, wd & 32'h1FFF, lat_cfg + 2, "R4");
    end

    // R11 back-to-back refused accesses keep pulses single
    access(1, 0, 1, 16'h0201, 32'h1, 0, 1, 32'h0, 1, "R11");
    access(1, 0, 1, 16'h0202, 32'h1, 0, 1, 32'h0, 1, "R11");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule